// File: doc/BRIEF.md
# Three-Slot Event Timestamp Capture

This block keeps three snapshot slots of the calendar time. Each slot watches one event source chosen by its own mode code. The sources are an edge on an external timestamp pin, an entry into battery supply, and a return to main supply. When its chosen event occurs, the slot copies the live seconds, minutes, hours, day, month and year fields. A slot in a "first" mode keeps the earliest capture until a clear. A slot in a "last" mode is overwritten by every qualifying event.

The supply monitor drives the two supply events as one-cycle strobes in the block's clock domain. The timestamp pin is asynchronous. It passes through a two-stage synchroniser and an edge detector, and a sense input selects the active polarity. A clear strobe empties every slot and re-arms first-event capture.

Each slot is a two-state machine. SLOT_EMPTY leaves on transition CAPTURE_FIRST to SLOT_HELD when a qualifying event arrives. SLOT_HELD stays in SLOT_HELD on transition OVERWRITE when a last-mode event arrives. It stays there on transition IGNORE when a first-mode event arrives. Both states return to SLOT_EMPTY on transition CLEAR.

Top module: `evts_capture`

## Requirements
- R1: After reset all three snapshots are zero and `ts_flags` is 3'b000.
- R2: A snapshot is the record {year[38:31], month[30:26], day[25:20], hour[19:14], minute[13:7], second[6:0]} of the live fields at the capturing clock edge. Slot 1 sets `ts_flags[0]`, slot 2 sets `ts_flags[1]` and slot 3 sets `ts_flags[2]`.
- R3: A pin edge is active when it is rising with `ts_sense`=0 and falling with `ts_sense`=1. Suppose the new pin level is first sampled at clock edge E0. The capture then occurs at edge E2, and its result is visible after E2. Nothing changes after E0 or after E1.
- R4: Slot 1 mode is `ts_mode[1:0]`: 0 off, 1 first pin edge, 2 last pin edge.
- R5: Slot 2 mode is `ts_mode[4:2]`: 0 off, 1 first battery entry, 2 last battery entry, 3 last return to main supply, 4 first pin edge, 5 last pin edge.
- R6: Slot 3 mode is `ts_mode[7:6]`: 0 off, 1 first battery entry, 2 last battery entry, 3 last return to main supply.
- R7: A held slot in a first mode keeps its snapshot unchanged on later qualifying events until a clear.
- R8: A slot in a last mode takes a new snapshot on every qualifying event.
- R9: A `bat_enter` or `main_return` strobe sampled at edge E0 is captured at E0, and the snapshot and flag are visible after E0.
- R10: A `ts_clear` sampled at edge E0 zeroes all snapshots and flags after E0. It takes priority over any event at the same edge and re-arms first-mode capture.
- R11: The unused codes (slot 1 code 3, slot 2 codes 6 and 7), the off code and `ts_mode[5]` cause no capture. Snapshots and flags stay unchanged.
- R12: Changing a mode code does not alter a snapshot or flag that is already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_mode | input | 8 | Packed mode codes of the three slots |
| ts_sense | input | 1 | Active pin edge: 0 rising, 1 falling |
| ts_pin | input | 1 | Asynchronous timestamp pin |
| bat_enter | input | 1 | One-cycle strobe: switched to battery supply |
| main_return | input | 1 | One-cycle strobe: returned to main supply |
| ts_clear | input | 1 | One-cycle strobe: empty all slots |
| live_sec | input | 7 | Live seconds field |
| live_min | input | 7 | Live minutes field |
| live_hour | input | 6 | Live hours field |
| live_day | input | 6 | Live day-of-month field |
| live_mon | input | 5 | Live month field |
| live_year | input | 8 | Live year field |
| snap1 | output | 39 | Slot 1 snapshot record |
| snap2 | output | 39 | Slot 2 snapshot record |
| snap3 | output | 39 | Slot 3 snapshot record |
| ts_flags | output | 3 | Per-slot captured flags |

## Verification
Supply strobes and the clear take effect at the edge that samples them. Their results are due after that single edge. A pin change becomes visible two edges after the edge that first samples it.

The bench's reference model keeps a three-deep history of pin samples. It updates its slot images at each rising edge, from the same inputs the design samples there. The model and the design outputs are compared at every falling edge, half a period after any change.

The directed checks on pin latency sample after E0, after E1 and after E2. Only the last of the three may show the capture.

// File: rtl/evts_pkg.sv
package evts_pkg;
    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HR_W   = 6;
    localparam int DAY_W  = 6;
    localparam int MON_W  = 5;
    localparam int YR_W   = 8;
    localparam int REC_W  = SEC_W + MIN_W + HR_W + DAY_W + MON_W + YR_W;
    localparam int NSLOT  = 3;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {SRC_NONE, SRC_PIN, SRC_BAT, SRC_MAIN} src_e;

    typedef struct packed {
        src_e src;
        logic keep_first;
    } slot_cfg_t;

    typedef enum logic {SLOT_EMPTY, SLOT_HELD} slot_st_e;

    // Field position and width of each slot's mode code (a neighbour decodes them)
    function automatic int code_lsb(input int kind);
        return (kind == 0) ? 0 : (kind == 1) ? 2 : 6;
    endfunction

    function automatic int code_width(input int kind);
        return (kind == 1) ? 3 : 2;
    endfunction

    function automatic slot_cfg_t decode_mode(input int kind, input logic [CODE_W-1:0] code);
        slot_cfg_t c;
        c.src        = SRC_NONE;
        c.keep_first = 1'b0;
        if (kind == 0) begin
            case (code)
                3'd1: begin c.src = SRC_PIN;  c.keep_first = 1'b1; end
                3'd2: begin c.src = SRC_PIN;  c.keep_first = 1'b0; end
                default: ;
            endcase
        end else if (kind == 1) begin
            case (code)
                3'd1: begin c.src = SRC_BAT;  c.keep_first = 1'b1; end
                3'd2: begin c.src = SRC_BAT;  c.keep_first = 1'b0; end
                3'd3: begin c.src = SRC_MAIN; c.keep_first = 1'b0; end
                3'd4: begin c.src = SRC_PIN;  c.keep_first = 1'b1; end
                3'd5: begin c.src = SRC_PIN;  c.keep_first = 1'b0; end
                default: ;
            endcase
        end else begin
            case (code)
                3'd1: begin c.src = SRC_BAT;  c.keep_first = 1'b1; end
                3'd2: begin c.src = SRC_BAT;  c.keep_first = 1'b0; end
                3'd3: begin c.src = SRC_MAIN; c.keep_first = 1'b0; end
                default: ;
            endcase
        end
        return c;
    endfunction
endpackage

// File: rtl/evts_pin_edge.sv
// Synchroniser chain plus polarity-selectable edge detector for the timestamp pin (R3)
module evts_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sense_fall,
    output logic edge_hit
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;
    logic                   level;

    assign level = chain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[SYNC_STAGES-2:0], pin};
            prev  <= level;
        end
    end

    always_comb begin
        if (sense_fall) edge_hit = prev & ~level;
        else            edge_hit = ~prev & level;
    end
endmodule

// File: rtl/evts_slot.sv
// One capture slot: SLOT_EMPTY / SLOT_HELD machine with first/last retention
module evts_slot
    import evts_pkg::*;
#(
    parameter int KIND    = 0,
    parameter int FIELD_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [FIELD_W-1:0] mode_code,
    input  logic               pin_ev,
    input  logic               bat_ev,
    input  logic               main_ev,
    input  logic [REC_W-1:0]   live_rec,
    output logic [REC_W-1:0]   snap,
    output logic               held
);
    slot_st_e         st_q, st_d;
    slot_cfg_t        cfg;
    logic [CODE_W-1:0] code_ext;
    logic             hit;
    logic             take;

    always_comb begin
        code_ext              = '0;
        code_ext[FIELD_W-1:0] = mode_code;
    end

    assign cfg = decode_mode(KIND, code_ext);

    always_comb begin
        unique case (cfg.src)
            SRC_PIN:  hit = pin_ev;
            SRC_BAT:  hit = bat_ev;
            SRC_MAIN: hit = main_ev;
            default:  hit = 1'b0;
        endcase
    end

    // Transitions: CAPTURE_FIRST, OVERWRITE, IGNORE, CLEAR
    always_comb begin
        st_d = st_q;
        take = 1'b0;
        unique case (st_q)
            SLOT_EMPTY: begin
                if (clr) begin
                    st_d = SLOT_EMPTY;
                end else if (hit) begin
                    st_d = SLOT_HELD;
                    take = 1'b1;
                end
            end
            SLOT_HELD: begin
                if (clr) begin
                    st_d = SLOT_EMPTY;
                end else if (hit && !cfg.keep_first) begin
                    take = 1'b1;
                end
            end
            default: st_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SLOT_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    snap <= '0;
        else if (clr)  snap <= '0;
        else if (take) snap <= live_rec;
    end

    assign held = (st_q == SLOT_HELD);
endmodule

// File: rtl/evts_capture.sv
module evts_capture
    import evts_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       ts_mode,
    input  logic             ts_sense,
    input  logic             ts_pin,
    input  logic             bat_enter,
    input  logic             main_return,
    input  logic             ts_clear,
    input  logic [SEC_W-1:0] live_sec,
    input  logic [MIN_W-1:0] live_min,
    input  logic [HR_W-1:0]  live_hour,
    input  logic [DAY_W-1:0] live_day,
    input  logic [MON_W-1:0] live_mon,
    input  logic [YR_W-1:0]  live_year,
    output logic [REC_W-1:0] snap1,
    output logic [REC_W-1:0] snap2,
    output logic [REC_W-1:0] snap3,
    output logic [NSLOT-1:0] ts_flags
);
    logic [REC_W-1:0] live_rec;
    logic             pin_ev;
    logic [REC_W-1:0] snap_arr [NSLOT];
    logic             unused_mode_gap;

    assign live_rec        = {live_year, live_mon, live_day, live_hour, live_min, live_sec};
    assign unused_mode_gap = ts_mode[5];

    evts_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (ts_pin),
        .sense_fall (ts_sense),
        .edge_hit   (pin_ev)
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        localparam int LSB = code_lsb(k);
        localparam int FW  = code_width(k);
        evts_slot #(.KIND(k), .FIELD_W(FW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (ts_clear),
            .mode_code (ts_mode[LSB +: FW]),
            .pin_ev    (pin_ev),
            .bat_ev    (bat_enter),
            .main_ev   (main_return),
            .live_rec  (live_rec),
            .snap      (snap_arr[k]),
            .held      (ts_flags[k])
        );
    end

    assign snap1 = snap_arr[0];
    assign snap2 = snap_arr[1];
    assign snap3 = snap_arr[2];
endmodule

// File: rtl/evts_capture_chk.sv
module evts_capture_chk
    import evts_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       ts_mode,
    input logic             bat_enter,
    input logic             main_return,
    input logic             ts_clear,
    input logic [SEC_W-1:0] live_sec,
    input logic [MIN_W-1:0] live_min,
    input logic [HR_W-1:0]  live_hour,
    input logic [DAY_W-1:0] live_day,
    input logic [MON_W-1:0] live_mon,
    input logic [YR_W-1:0]  live_year,
    input logic [REC_W-1:0] snap1,
    input logic [REC_W-1:0] snap2,
    input logic [REC_W-1:0] snap3,
    input logic [NSLOT-1:0] ts_flags
);
    logic [REC_W-1:0] rec_now;
    assign rec_now = {live_year, live_mon, live_day, live_hour, live_min, live_sec};

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ts_clear |=> (ts_flags == '0 && snap1 == '0 && snap2 == '0 && snap3 == '0)); // R10

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_clear |=> ((ts_flags & $past(ts_flags)) == $past(ts_flags))); // R12

    AST_FIRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_mode[1:0] == 2'd1 && ts_flags[0] && !ts_clear) |=> $stable(snap1)); // R7

    AST_LAST_BAT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_mode[7:6] == 2'd2 && bat_enter && !ts_clear) |=> (ts_flags[2] && snap3 == $past(rec_now))); // R8

    AST_MAIN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_mode[7:6] == 2'd3 && main_return && !ts_clear) |=> (snap3 == $past(rec_now))); // R6

    AST_UNUSED_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_mode[4:2] >= 3'd6 && !ts_clear) |=> ($stable(snap2) && $stable(ts_flags[1]))); // R11
endmodule

bind evts_capture evts_capture_chk u_chk (.*);

// File: tb/evts_capture_bench.sv
module evts_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ts_mode = 8'h00;
    logic        ts_sense = 1'b0;
    logic        ts_pin = 1'b0;
    logic        bat_enter = 1'b0;
    logic        main_return = 1'b0;
    logic        ts_clear = 1'b0;
    logic [15:0] tcnt = 16'd0;
    logic [6:0]  live_sec;
    logic [6:0]  live_min;
    logic [5:0]  live_hour;
    logic [5:0]  live_day;
    logic [4:0]  live_mon;
    logic [7:0]  live_year;
    logic [38:0] snap1, snap2, snap3;
    logic [2:0]  ts_flags;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    logic [38:0] m_snap [3];
    bit          m_flag [3];
    int          h1, h2, h3;

    always #5 clk = ~clk;

    assign live_sec  = tcnt[6:0];
    assign live_min  = 7'(tcnt * 3);
    assign live_hour = 6'(tcnt * 5);
    assign live_day  = 6'(tcnt + 7);
    assign live_mon  = 5'(tcnt * 7);
    assign live_year = 8'(tcnt * 11);

    evts_capture u_evts_capture (
        .clk(clk), .rst_n(rst_n), .ts_mode(ts_mode), .ts_sense(ts_sense),
        .ts_pin(ts_pin), .bat_enter(bat_enter), .main_return(main_return),
        .ts_clear(ts_clear), .live_sec(live_sec), .live_min(live_min),
        .live_hour(live_hour), .live_day(live_day), .live_mon(live_mon),
        .live_year(live_year), .snap1(snap1), .snap2(snap2), .snap3(snap3),
        .ts_flags(ts_flags)
    );

    // src: 0 none, 1 pin, 2 battery, 3 main; first = keep earliest
    function automatic void model_mode(input int slot, input int mb, output int src, output bit first);
        int code;
        src = 0; first = 0;
        if (slot == 0) begin
            code = mb & 3;
            if (code == 1) begin src = 1; first = 1; end
            if (code == 2) begin src = 1; first = 0; end
        end else if (slot == 1) begin
            code = (mb >> 2) & 7;
            case (code)
                1: begin src = 2; first = 1; end
                2: begin src = 2; first = 0; end
                3: begin src = 3; first = 0; end
                4: begin src = 1; first = 1; end
                5: begin src = 1; first = 0; end
                default: src = 0;
            endcase
        end else begin
            code = (mb >> 6) & 3;
            if (code == 1) begin src = 2; first = 1; end
            if (code == 2) begin src = 2; first = 0; end
            if (code == 3) begin src = 3; first = 0; end
        end
    endfunction

    always @(posedge clk) begin
        bit pin_now;
        logic [38:0] rec;
        int src;
        bit first;
        bit ev;
        if (!rst_n) begin
            for (int s = 0; s < 3; s++) begin m_snap[s] = '0; m_flag[s] = 0; end
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            pin_now = ts_sense ? (h3 == 1 && h2 == 0) : (h3 == 0 && h2 == 1);
            rec = {live_year, live_mon, live_day, live_hour, live_min, live_sec};
            for (int s = 0; s < 3; s++) begin
                if (ts_clear) begin
                    m_snap[s] = '0; m_flag[s] = 0;
                end else begin
                    model_mode(s, int'(ts_mode), src, first);
                    ev = (src == 1 && pin_now) || (src == 2 && bat_enter) || (src == 3 && main_return);
                    if (ev && (!m_flag[s] || !first)) begin
                        m_snap[s] = rec; m_flag[s] = 1;
                    end
                end
            end
            h3 = h2; h2 = h1; h1 = int'(ts_pin);
        end
    end

    always @(negedge clk) begin
        tcnt <= tcnt + 16'd1;
        if (rst_n && !done) begin
            n_cmp++;
            if (ts_flags != {m_flag[2], m_flag[1], m_flag[0]} || snap1 != m_snap[0] ||
                snap2 != m_snap[1] || snap3 != m_snap[2]) begin
                n_bad++;
                $display("FAIL %s model: flags %b exp %b s1 %h/%h s2 %h/%h s3 %h/%h", cur_req,
                         ts_flags, {m_flag[2], m_flag[1], m_flag[0]}, snap1, m_snap[0],
                         snap2, m_snap[1], snap3, m_snap[2]);
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk); ts_pin = v; tick(4);
    endtask

    task automatic pulse_bat();
        @(negedge clk); bat_enter = 1'b1; @(negedge clk); bat_enter = 1'b0; tick(1);
    endtask

    task automatic pulse_main();
        @(negedge clk); main_return = 1'b1; @(negedge clk); main_return = 1'b0; tick(1);
    endtask

    task automatic do_clear();
        @(negedge clk); ts_clear = 1'b1; @(negedge clk); ts_clear = 1'b0; tick(1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [38:0] keep1, keep2, keep3;
        tick(3);
        chk("R1 flags", 64'(ts_flags), 64'd0);
        chk("R1 snaps", 64'(snap1 | snap2 | snap3), 64'd0);
        rst_n = 1'b1;
        tick(2);
        chk("R1 after release", 64'(ts_flags), 64'd0);

        // R4/R5/R6: slot1 first pin, slot2 last pin, slot3 last battery
        cur_req = "R3";
        ts_mode = 8'h95;
        tick(1);
        ts_pin = 1'b1;          // first sampled at E0
        tick(1);                 // after E0
        chk("R3 after E0", 64'(ts_flags), 64'd0);
        tick(1);                 // after E1
        chk("R3 after E1", 64'(ts_flags), 64'd0);
        tick(1);                 // after E2
        chk("R3 after E2", 64'(ts_flags), 64'b011);
        chk("R2 slots 1 and 2 same record", 64'(snap1 == snap2), 64'd1);
        chk("R2 flag bit 2 clear", 64'(ts_flags[2]), 64'd0);
        cur_req = "R4";
        tick(3);
        set_pin(1'b0);           // falling edge, not active with sense 0
        chk("R3 inactive edge", 64'(ts_flags), 64'b011);
        keep1 = snap1; keep2 = snap2;
        cur_req = "R7";
        set_pin(1'b1);
        chk("R7 first-mode slot1 unchanged", 64'(snap1), 64'(keep1));
        chk("R8 last-mode slot2 overwritten", 64'(snap2 != keep2), 64'd1);

        // R9: supply strobe latency
        cur_req = "R9";
        @(negedge clk); bat_enter = 1'b1;
        @(negedge clk); bat_enter = 1'b0;
        chk("R9 flag after E0", 64'(ts_flags[2]), 64'd1);
        keep3 = snap3;
        tick(3);
        cur_req = "R8";
        pulse_bat();
        chk("R8 slot3 last battery overwrite", 64'(snap3 != keep3), 64'd1);

        // R3 falling sense
        cur_req = "R3";
        ts_sense = 1'b1;
        keep2 = snap2;
        set_pin(1'b0);
        chk("R3 falling edge captured", 64'(snap2 != keep2), 64'd1);

        // R10 clear wins over simultaneous event
        cur_req = "R10";
        @(negedge clk); ts_clear = 1'b1; bat_enter = 1'b1;
        @(negedge clk); ts_clear = 1'b0; bat_enter = 1'b0;
        chk("R10 flags zero", 64'(ts_flags), 64'd0);
        chk("R10 snaps zero", 64'(snap1 | snap2 | snap3), 64'd0);
        set_pin(1'b1);
        set_pin(1'b0);
        chk("R10 rearmed slot1", 64'(ts_flags[0]), 64'd1);

        // R11 unused codes and bit 5
        cur_req = "R11";
        ts_mode = 8'h3B;
        do_clear();
        set_pin(1'b1);
        set_pin(1'b0);
        pulse_bat();
        pulse_main();
        chk("R11 no capture", 64'(ts_flags), 64'd0);
        ts_mode = 8'h1C;         // slot2 code 7
        set_pin(1'b1);
        set_pin(1'b0);
        chk("R11 code 7 idle", 64'(ts_flags), 64'd0);

        // R5/R6: slot2 first battery, slot3 last main
        cur_req = "R5";
        ts_mode = 8'hC4;
        do_clear();
        pulse_bat();
        keep2 = snap2;
        pulse_bat();
        chk("R5 slot2 first battery kept", 64'(snap2), 64'(keep2));
        cur_req = "R6";
        pulse_main();
        chk("R6 slot3 main capture", 64'(ts_flags), 64'b110);

        // slot2 last main, slot3 first battery
        ts_mode = 8'h4C;
        do_clear();
        pulse_main();
        chk("R5 slot2 main", 64'(ts_flags), 64'b010);
        pulse_bat();
        keep3 = snap3;
        pulse_bat();
        chk("R6 slot3 first battery kept", 64'(snap3), 64'(keep3));

        // slot2 first pin, slot1 last pin
        cur_req = "R5";
        ts_mode = 8'h12;
        ts_sense = 1'b0;
        do_clear();
        set_pin(1'b1);
        keep2 = snap2;
        set_pin(1'b0);
        set_pin(1'b1);
        chk("R5 slot2 first pin kept", 64'(snap2), 64'(keep2));
        chk("R4 slot1 last pin newer", 64'(snap1 != keep2), 64'd1);

        // R12 mode change keeps held content
        cur_req = "R12";
        keep1 = snap1; keep2 = snap2;
        ts_mode = 8'h00;
        set_pin(1'b0);
        set_pin(1'b1);
        pulse_bat();
        chk("R12 flags held", 64'(ts_flags), 64'b011);
        chk("R12 slot1 held", 64'(snap1), 64'(keep1));
        chk("R12 slot2 held", 64'(snap2), 64'(keep2));
        tick(3);
        finish_run();
    end
endmodule